// File: doc/BRIEF.md
# Drive Phase-Line Command and Sense Sequencer

This block drives the addressed control interface of a disk drive. Three phase lines and one select line form a 4-bit code that points at one of sixteen registers inside the drive. A strobe pulse on the same interface tells the drive to carry out the command that the code names. A single sense line returns the status bit that the code addresses, and that bit is active-low. The host presents a 4-bit code and asks for an action (a strobed command) or a sense (a status read). The block then runs the whole line sequence, with timing derived from a clock-cycles-per-microsecond parameter.

Every transaction starts from the relaxed code (phase lines at 3). The select line then takes code bit 3, and after that the phase lines take bits 2:0. The block waits a settle time before it either pulses the strobe, with settle, width and hold timing, or samples the sense line. Typical action codes are step outward (0), step inward (4), step (1), motor on (2), motor off (6), eject (7) and the two encoding-mode selects (9 and 13). Typical sense codes are disk in (8), write protect (9), track zero (10), seek complete (14), drive present (7) and mode (13). The block does not decode the codes, so any 4-bit value is carried out the same way.

Top module: `drive_line_sequencer`

## Requirements
- R1: After reset the phase lines read 3, the select line, strobe, busy, done and senseResult are all 0.
- R2: A request (reqValid high while busy is low) is accepted at a clock edge. In the cycle after that edge busy is 1, the phase lines read 3 and the select line keeps its previous value.
- R3: One cycle after the relax step the select line takes code bit 3. One cycle after that the phase lines take code bits 2:0.
- R4: For an action (reqIsAction=1), the strobe rises S = SETTLE_US*CYC_PER_US cycles after the phase lines take the code. It stays high for STROBE_US*CYC_PER_US cycles and then stays low for HOLD_US*CYC_PER_US cycles, after which the transaction ends. The strobe is high only while busy.
- R5: For a sense (reqIsAction=0), the sense line is sampled S cycles after the phase lines take the code, and that sample ends the transaction. senseResult becomes the inverse of the sampled level (low means true) and holds until the next sense. The strobe does not pulse during a sense.
- R6: A request that arrives while busy is ignored. The lines, the timing and the latched code of the running transaction are unchanged.
- R7: done is a one-cycle pulse in the first cycle with busy low after a transaction. A new request may be accepted in that same cycle.
- R8: While idle, the phase and select lines keep the last code that was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqIsAction | input | 1 | 1 = action with strobe, 0 = sense read |
| reqCode | input | 4 | Drive register code; bit 3 is select, bits 2:0 are phase |
| senseLine | input | 1 | Drive sense line, active-low |
| phaseLines | output | 3 | Phase lines to the drive |
| selLine | output | 1 | Select line to the drive |
| strobeLine | output | 1 | Command strobe to the drive |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| senseResult | output | 1 | Last sensed condition, true-high |

## Verification
A wrong sequencer state shows up on the lines within one cycle of acceptance. The relax value, the select update and the phase update each have a fixed cycle, so a skipped or reordered step is caught at the cycle where it goes wrong. A timer that loads or counts wrongly moves the strobe edges, the sample point or the fall of busy by at least one cycle, and the bench compares every cycle of every transaction against an arithmetic timeline. An accepted stray request during busy would change the lines or the length of the transaction before done.

// File: rtl/drive_line_seq_pkg.sv
package drive_line_seq_pkg;
  typedef struct packed {
    logic accept;
    logic setRelax;
    logic setSel;
    logic setPhase;
    logic loadSettle;
    logic loadStrobe;
    logic loadHold;
    logic timerDec;
    logic strobeOn;
    logic strobeOff;
    logic sample;
  } seqCtl_t;

  localparam logic [2:0] RELAX_PHASE = 3'd3;
endpackage

// File: rtl/drive_line_seq_ctrl.sv
module drive_line_seq_ctrl
  import drive_line_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqIsAction,
  input  logic    timerZero,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done
);
  typedef enum logic [2:0] {S_IDLE, S_SEL, S_PHASE, S_SETTLE, S_STROBE, S_HOLD} seqState_t;

  seqState_t stateQ, stateNext;
  logic      isActQ;
  logic      doneQ;

  always_comb begin
    ctl       = '0;
    stateNext = stateQ;
    unique case (stateQ)
      S_IDLE: if (reqValid) begin
        ctl.accept   = 1'b1;
        ctl.setRelax = 1'b1;
        stateNext    = S_SEL;
      end
      S_SEL: begin
        ctl.setSel = 1'b1;
        stateNext  = S_PHASE;
      end
      S_PHASE: begin
        ctl.setPhase   = 1'b1;
        ctl.loadSettle = 1'b1;
        stateNext      = S_SETTLE;
      end
      S_SETTLE: begin
        if (!timerZero) ctl.timerDec = 1'b1;
        else if (isActQ) begin
          ctl.strobeOn   = 1'b1;
          ctl.loadStrobe = 1'b1;
          stateNext      = S_STROBE;
        end else begin
          ctl.sample = 1'b1;
          stateNext  = S_IDLE;
        end
      end
      S_STROBE: begin
        if (!timerZero) ctl.timerDec = 1'b1;
        else begin
          ctl.strobeOff = 1'b1;
          ctl.loadHold  = 1'b1;
          stateNext     = S_HOLD;
        end
      end
      S_HOLD: begin
        if (!timerZero) ctl.timerDec = 1'b1;
        else stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      isActQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (ctl.accept) isActQ <= reqIsAction;
      doneQ <= (stateQ != S_IDLE) && (stateNext == S_IDLE);
    end
  end

  assign busy = (stateQ != S_IDLE);
  assign done = doneQ;

  // R7: completion is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: done appears only in an idle cycle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/drive_line_seq_dpath.sv
module drive_line_seq_dpath
  import drive_line_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int STROBE_CYC = 8,
  parameter int HOLD_CYC   = 4,
  parameter int TW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seqCtl_t       ctl,
  input  logic [3:0]    reqCode,
  input  logic          senseLine,
  output logic [2:0]    phaseLines,
  output logic          selLine,
  output logic          strobeLine,
  output logic          senseResult,
  output logic          timerZero,
  output logic [3:0]    codeQ
);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] STROBE_LD = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0] HOLD_LD   = TW'(HOLD_CYC - 1);

  logic [TW-1:0] timerQ;
  logic [2:0]    phaseQ;
  logic          selQ, strobeQ, resultQ;
  logic [3:0]    codeLatchQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerQ     <= '0;
      phaseQ     <= RELAX_PHASE;
      selQ       <= 1'b0;
      strobeQ    <= 1'b0;
      resultQ    <= 1'b0;
      codeLatchQ <= '0;
    end else begin
      if (ctl.accept)   codeLatchQ <= reqCode;
      if (ctl.setRelax) phaseQ     <= RELAX_PHASE;
      if (ctl.setSel)   selQ       <= codeLatchQ[3];
      if (ctl.setPhase) phaseQ     <= codeLatchQ[2:0];
      if (ctl.loadSettle)      timerQ <= SETTLE_LD;
      else if (ctl.loadStrobe) timerQ <= STROBE_LD;
      else if (ctl.loadHold)   timerQ <= HOLD_LD;
      else if (ctl.timerDec)   timerQ <= timerQ - 1'b1;
      if (ctl.strobeOn)       strobeQ <= 1'b1;
      else if (ctl.strobeOff) strobeQ <= 1'b0;
      if (ctl.sample) resultQ <= ~senseLine;
    end
  end

  assign phaseLines  = phaseQ;
  assign selLine     = selQ;
  assign strobeLine  = strobeQ;
  assign senseResult = resultQ;
  assign timerZero   = (timerQ == '0);
  assign codeQ       = codeLatchQ;

  // R3: the select line only moves while the phase lines sit at the relax code
  assert_sel_after_relax_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(selLine) |-> (phaseLines == RELAX_PHASE));
  // R5: the result only changes on a sample command
  assert_result_sampled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.sample |=> $stable(senseResult));
endmodule

// File: rtl/drive_line_sequencer.sv
module drive_line_sequencer
  import drive_line_seq_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int SETTLE_US  = 1,
  parameter int STROBE_US  = 2,
  parameter int HOLD_US    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqIsAction,
  input  logic [3:0] reqCode,
  input  logic       senseLine,
  output logic [2:0] phaseLines,
  output logic       selLine,
  output logic       strobeLine,
  output logic       busy,
  output logic       done,
  output logic       senseResult
);
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int STROBE_CYC = STROBE_US * CYC_PER_US;
  localparam int HOLD_CYC   = HOLD_US * CYC_PER_US;
  localparam int MAX_A      = (SETTLE_CYC > STROBE_CYC) ? SETTLE_CYC : STROBE_CYC;
  localparam int MAX_CYC    = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int TW         = $clog2(MAX_CYC + 1);

  seqCtl_t    ctl;
  logic       timerZero;
  logic [3:0] codeQ;

  drive_line_seq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsAction(reqIsAction),
    .timerZero(timerZero), .ctl(ctl), .busy(busy), .done(done)
  );

  drive_line_seq_dpath #(
    .SETTLE_CYC(SETTLE_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC), .TW(TW)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqCode(reqCode), .senseLine(senseLine),
    .phaseLines(phaseLines), .selLine(selLine), .strobeLine(strobeLine),
    .senseResult(senseResult), .timerZero(timerZero), .codeQ(codeQ)
  );

  // R2: every transaction opens on the relax code with select untouched
  assert_relax_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phaseLines == RELAX_PHASE && $stable(selLine)));
  // R4: strobe is confined to a transaction
  assert_strobe_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobeLine |-> busy);
  // R6: a request during busy leaves the latched code alone
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reqValid) |=> $stable(codeQ));
  // R8: idle without request keeps the lines
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reqValid) |=> ($stable(phaseLines) && $stable(selLine)));
endmodule

// File: tb/drive_line_sequencer_tb.sv
module drive_line_sequencer_tb_top;
  localparam int CPU = 4;
  localparam int S = 1 * CPU;
  localparam int T = 2 * CPU;
  localparam int H = 1 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqIsAction = 1'b0;
  logic [3:0] reqCode = 4'd0;
  logic senseLine = 1'b1;
  logic [2:0] phaseLines;
  logic selLine, strobeLine, busy, done, senseResult;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [2:0] prevPhase = 3'd3;
  logic       prevSel = 1'b0;
  logic       lastResult = 1'b0;

  always #4 clk = ~clk;

  drive_line_sequencer #(.CYC_PER_US(CPU), .SETTLE_US(1), .STROBE_US(2), .HOLD_US(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsAction(reqIsAction),
    .reqCode(reqCode), .senseLine(senseLine), .phaseLines(phaseLines),
    .selLine(selLine), .strobeLine(strobeLine), .busy(busy), .done(done),
    .senseResult(senseResult)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Starts a request right after a negedge and returns at the negedge of the done cycle.
  task automatic runOp(input logic [3:0] code, input logic isAct, input logic lvl,
                       input bit inject);
    int endN;
    logic [2:0] ePh;
    logic eSel, eStb, eBusy, eDone;
    endN = isAct ? (2 + S + T + H) : (2 + S);
    reqValid = 1'b1; reqCode = code; reqIsAction = isAct; senseLine = lvl;
    for (int n = 0; n <= endN; n++) begin
      @(negedge clk);
      reqValid = 1'b0;
      ePh   = (n < 2) ? 3'd3 : code[2:0];
      eSel  = (n == 0) ? prevSel : code[3];
      eStb  = isAct && (n >= 2 + S) && (n < 2 + S + T);
      eBusy = (n < endN);
      eDone = (n == endN);
      if (n == 0)
        chk("R2 relax-first", {1'b0, phaseLines, selLine, strobeLine, busy, done},
            {1'b0, ePh, eSel, eStb, eBusy, eDone});
      else if (n < 2)
        chk("R3 select-then-phase", {1'b0, phaseLines, selLine, strobeLine, busy, done},
            {1'b0, ePh, eSel, eStb, eBusy, eDone});
      else if (n == endN)
        chk("R7 done pulse", {1'b0, phaseLines, selLine, strobeLine, busy, done},
            {1'b0, ePh, eSel, eStb, eBusy, eDone});
      else if (isAct)
        chk(inject ? "R6 ignored request / R4 timing" : "R4 strobe timing",
            {1'b0, phaseLines, selLine, strobeLine, busy, done},
            {1'b0, ePh, eSel, eStb, eBusy, eDone});
      else
        chk(inject ? "R6 ignored request / R5 timing" : "R5 sense timing",
            {1'b0, phaseLines, selLine, strobeLine, busy, done},
            {1'b0, ePh, eSel, eStb, eBusy, eDone});
      if (inject && n == 1) begin
        reqValid = 1'b1; reqCode = ~code; reqIsAction = ~isAct;
      end
      if (inject && n == 3) begin
        reqValid = 1'b1; reqCode = code ^ 4'h5;
      end
    end
    reqValid = 1'b0;
    if (!isAct) lastResult = ~lvl;
    chk(isAct ? "R5 result held over action" : "R5 sensed value inverted",
        {7'd0, senseResult}, {7'd0, lastResult});
    prevPhase = code[2:0];
    prevSel = code[3];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset state", {1'b0, phaseLines, selLine, strobeLine, busy, done},
        {1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0});
    chk("R1 reset result", {7'd0, senseResult}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Sweep every code, both kinds, both sense levels
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        runOp(4'(c), m[1], m[0], (c % 3) == 0);
        // R8: idle keeps lines for a couple of cycles
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk("R8 idle hold", {3'd0, phaseLines, selLine, busy},
              {3'd0, prevPhase, prevSel, 1'b0});
        end
      end
    end
    // R7: back-to-back requests accepted in the done cycle
    runOp(4'd9, 1'b0, 1'b0, 0);
    runOp(4'd2, 1'b1, 1'b1, 0);
    runOp(4'd14, 1'b0, 1'b1, 0);
    runOp(4'd7, 1'b1, 1'b0, 1);
    @(negedge clk);
    chk("R8 idle after chain", {3'd0, phaseLines, selLine, busy}, {3'd0, 3'd7, 1'b0, 1'b0});
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule